// File: doc/BRIEF.md
# Debug Register Bank Access Sequencer

This block turns single register commands into the ordered list of scan operations that reach a 32-entry debug register bank behind a debug TAP. A command can be a read or a write. It carries a 5-bit register number and, for writes, a 32-bit value. The sequencer first routes the TAP to the register-bank scan chain. It then performs the access and, for reads, returns the 32-bit register contents. Each scan operation goes to a downstream shift engine as one request: IR or DR, a bit count, the bits to send LSB first, and a flag that keeps the TAP out of Run-Test/Idle. The engine owns the TAP state walk and the bit clocking. It answers each request with a one-cycle acknowledge and the bits it captured.

Routing has three steps: a chain-select instruction, a chain-number DR shift, and the internal-test instruction. The sequencer remembers which chain it last routed. If the chain is already routed, it skips the first two steps. An external raw IR load or a reset makes it forget the routed chain.

Top module: `dbg_reg_seq`

## Requirements
- R1: `cmd_ready` is the inverse of `busy`. A command is accepted on a rising edge where `cmd_valid` and `cmd_ready` are both high. `busy` is high from the next cycle until the cycle after the final scan is acknowledged.
- R2: With no chain remembered, an access starts with three requests. First an IR shift of `IR_LEN` bits carrying `IR_CHAIN_SEL` (default 4'h2). Then a DR shift of `CHAIN_LEN` bits (default 4) carrying `CHAIN_ID` (default 2). Then an IR shift carrying `IR_INTEST` (default 4'hC).
- R3: When the remembered chain equals `CHAIN_ID`, the access starts directly with the `IR_INTEST` IR shift.
- R4: A one-cycle pulse on `raw_ir_load` clears the remembered chain, so the next access performs the full three-step routing of R2.
- R5: Every routing request (IR shifts and the chain-number shift) has `sh_noidle` = 1. The access shifts have `sh_noidle` = 0.
- R6: A write issues one DR shift of 38 bits. `sh_tdi[31:0]` holds the write data, `[36:32]` the register number, and `[37]` = 1 (write).
- R7: A read issues a 6-bit DR shift with `sh_tdi[4:0]` = register number and `[5]` = 0 (read). It then issues a 32-bit DR shift with all-zero TDI. The captured `sh_tdo` of that second shift appears on `rd_data`, with a one-cycle `rd_valid` pulse in the cycle after its acknowledge.
- R8: `cmd_valid` while `busy` is high is ignored. No extra scan requests are issued, and the running access completes with its own address and data.
- R9: After reset, `busy`, `sh_req` and `rd_valid` are 0 and `cmd_ready` is 1.
- R10: Once `sh_req` is raised, it stays high and `sh_ir`, `sh_len` and `sh_tdi` stay unchanged until `sh_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 5 | Register number |
| cmd_wdata | input | 32 | Write data |
| busy | output | 1 | Access in progress |
| rd_valid | output | 1 | One-cycle read-data strobe |
| rd_data | output | 32 | Read result |
| raw_ir_load | input | 1 | An outside IR load happened; forget routed chain |
| sh_req | output | 1 | Scan request to shift engine |
| sh_ir | output | 1 | 1 = IR shift, 0 = DR shift |
| sh_noidle | output | 1 | Skip Run-Test/Idle after this shift |
| sh_len | output | 6 | Bit count of the shift |
| sh_tdi | output | 38 | Bits to send, LSB first |
| sh_ack | input | 1 | Shift finished (one cycle) |
| sh_tdo | input | 32 | Bits captured by the last shift |

## Verification
A stale remembered chain shows up at the ports as a missing or extra chain-select and chain-number request at the start of the next access, right after the command is accepted. A corrupted step register shows up as a wrong IR code, length or TDI packing in the very next request. It can also appear as a read whose 32-bit shift is skipped, so no `rd_valid` arrives. A mis-held command register shows up only in the final access shift, several requests later. So the bench compares every logged request of every access, not just the returned data.

// File: rtl/dbg_reg_seq_pkg.sv
// Shared widths, step encoding and scan request record for the sequencer.
package dbg_reg_seq_pkg;
    parameter int DATA_W  = 32;
    parameter int ADDR_W  = 5;
    parameter int SHIFT_W = DATA_W + ADDR_W + 1;
    parameter int LEN_W   = $clog2(SHIFT_W + 1);

    typedef enum logic [2:0] {
        STEP_IDLE,
        STEP_SEL_IR,
        STEP_SEL_DR,
        STEP_TEST_IR,
        STEP_WR_DR,
        STEP_RD_ADDR,
        STEP_RD_DATA
    } step_e;

    typedef struct packed {
        logic               ir;
        logic               noidle;
        logic [LEN_W-1:0]   len;
        logic [SHIFT_W-1:0] tdi;
    } scan_op_t;
endpackage

// File: rtl/scan_chain_tracker.sv
// Remembers which scan chain the TAP is routed to.
// Assumes: set_pulse arrives when the chain-number shift is acknowledged;
// forget has priority over set in the same cycle.
module scan_chain_tracker #(
    parameter int CHAIN_LEN = 4,
    parameter logic [CHAIN_LEN-1:0] CHAIN_ID = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_pulse,
    input  logic [CHAIN_LEN-1:0] set_chain,
    input  logic                 forget,
    output logic                 hit
);
    logic                 known_q;
    logic [CHAIN_LEN-1:0] chain_q;

    // Track routed chain; clear on reset or outside IR load.
    always_ff @(posedge clk) begin
        if (!rst_n || forget) begin
            known_q <= 1'b0;
            chain_q <= '0;
        end else if (set_pulse) begin
            known_q <= 1'b1;
            chain_q <= set_chain;
        end
    end

    // Hit when the remembered chain is the target chain.
    always_comb hit = known_q && (chain_q == CHAIN_ID);

    // R4
    forget_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        forget |=> !hit);
endmodule

// File: rtl/scan_step_decoder.sv
// Turns the current step and held command into one scan request record.
// Assumes: codes fit in IR_LEN bits and the chain number in CHAIN_LEN bits.
module scan_step_decoder
    import dbg_reg_seq_pkg::*;
#(
    parameter int IR_LEN    = 4,
    parameter int CHAIN_LEN = 4,
    parameter logic [IR_LEN-1:0]    IR_CHAIN_SEL = 4'h2,
    parameter logic [IR_LEN-1:0]    IR_INTEST    = 4'hC,
    parameter logic [CHAIN_LEN-1:0] CHAIN_ID     = 2
) (
    input  step_e             step,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output scan_op_t          op
);
    localparam logic [LEN_W-1:0] IR_BITS    = LEN_W'(IR_LEN);
    localparam logic [LEN_W-1:0] CHAIN_BITS = LEN_W'(CHAIN_LEN);
    localparam logic [LEN_W-1:0] WR_BITS    = LEN_W'(SHIFT_W);
    localparam logic [LEN_W-1:0] RA_BITS    = LEN_W'(ADDR_W + 1);
    localparam logic [LEN_W-1:0] RD_BITS    = LEN_W'(DATA_W);

    // Build the request fields for each step.
    always_comb begin
        op = '0;
        unique case (step)
            STEP_SEL_IR: begin
                op.ir = 1'b1; op.noidle = 1'b1; op.len = IR_BITS;
                op.tdi[IR_LEN-1:0] = IR_CHAIN_SEL;
            end
            STEP_SEL_DR: begin
                op.noidle = 1'b1; op.len = CHAIN_BITS;
                op.tdi[CHAIN_LEN-1:0] = CHAIN_ID;
            end
            STEP_TEST_IR: begin
                op.ir = 1'b1; op.noidle = 1'b1; op.len = IR_BITS;
                op.tdi[IR_LEN-1:0] = IR_INTEST;
            end
            STEP_WR_DR: begin
                op.len = WR_BITS;
                op.tdi = {1'b1, addr, wdata};
            end
            STEP_RD_ADDR: begin
                op.len = RA_BITS;
                op.tdi[ADDR_W:0] = {1'b0, addr};
            end
            STEP_RD_DATA: op.len = RD_BITS;
            default: op = '0;
        endcase
    end
endmodule

// File: rtl/scan_step_ctrl.sv
// Walks routing and access steps for one command at a time.
// Assumes: the shift engine pulses ack once per request and accepts a new
// request only in the cycle after that ack.
module scan_step_ctrl
    import dbg_reg_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              chain_hit,
    input  logic              sh_ack,
    input  logic [DATA_W-1:0] sh_tdo,
    output step_e             step,
    output logic [ADDR_W-1:0] held_addr,
    output logic [DATA_W-1:0] held_wdata,
    output logic              chain_set,
    output logic              busy,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    step_e step_q, step_d;
    logic  write_q;
    logic  accept;

    always_comb accept = cmd_valid && (step_q == STEP_IDLE);

    // Choose the next step from the current one and the acknowledge.
    always_comb begin
        step_d = step_q;
        unique case (step_q)
            STEP_IDLE:    if (accept) step_d = chain_hit ? STEP_TEST_IR : STEP_SEL_IR;
            STEP_SEL_IR:  if (sh_ack) step_d = STEP_SEL_DR;
            STEP_SEL_DR:  if (sh_ack) step_d = STEP_TEST_IR;
            STEP_TEST_IR: if (sh_ack) step_d = write_q ? STEP_WR_DR : STEP_RD_ADDR;
            STEP_WR_DR:   if (sh_ack) step_d = STEP_IDLE;
            STEP_RD_ADDR: if (sh_ack) step_d = STEP_RD_DATA;
            STEP_RD_DATA: if (sh_ack) step_d = STEP_IDLE;
            default:      step_d = STEP_IDLE;
        endcase
    end

    // Step register.
    always_ff @(posedge clk) begin
        if (!rst_n) step_q <= STEP_IDLE;
        else        step_q <= step_d;
    end

    // Hold the command fields for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            write_q    <= 1'b0;
            held_addr  <= '0;
            held_wdata <= '0;
        end else if (accept) begin
            write_q    <= cmd_write;
            held_addr  <= cmd_addr;
            held_wdata <= cmd_wdata;
        end
    end

    // Capture read result and strobe it once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= (step_q == STEP_RD_DATA) && sh_ack;
            if ((step_q == STEP_RD_DATA) && sh_ack) rd_data <= sh_tdo;
        end
    end

    always_comb begin
        step      = step_q;
        busy      = (step_q != STEP_IDLE);
        chain_set = (step_q == STEP_SEL_DR) && sh_ack;
    end

    // R1
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> busy);
    // R7
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    // R7
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !busy);
endmodule

// File: rtl/dbg_reg_seq.sv
// Top: debug register bank access sequencer over a scan-shift engine.
// Assumes: engine handshake per scan_step_ctrl; chain cache flushed by
// raw_ir_load whenever any other agent loads the TAP instruction register.
module dbg_reg_seq
    import dbg_reg_seq_pkg::*;
#(
    parameter int IR_LEN    = 4,
    parameter int CHAIN_LEN = 4,
    parameter logic [IR_LEN-1:0]    IR_CHAIN_SEL = 4'h2,
    parameter logic [IR_LEN-1:0]    IR_INTEST    = 4'hC,
    parameter logic [CHAIN_LEN-1:0] CHAIN_ID     = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic               cmd_write,
    input  logic [ADDR_W-1:0]  cmd_addr,
    input  logic [DATA_W-1:0]  cmd_wdata,
    output logic               busy,
    output logic               rd_valid,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               raw_ir_load,
    output logic               sh_req,
    output logic               sh_ir,
    output logic               sh_noidle,
    output logic [LEN_W-1:0]   sh_len,
    output logic [SHIFT_W-1:0] sh_tdi,
    input  logic               sh_ack,
    input  logic [DATA_W-1:0]  sh_tdo
);
    step_e             step;
    logic [ADDR_W-1:0] held_addr;
    logic [DATA_W-1:0] held_wdata;
    logic              chain_set;
    logic              chain_hit;
    scan_op_t          op;

    scan_chain_tracker #(.CHAIN_LEN(CHAIN_LEN), .CHAIN_ID(CHAIN_ID)) u_track (
        .clk(clk), .rst_n(rst_n), .set_pulse(chain_set),
        .set_chain(CHAIN_ID), .forget(raw_ir_load), .hit(chain_hit)
    );

    scan_step_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .chain_hit(chain_hit),
        .sh_ack(sh_ack), .sh_tdo(sh_tdo), .step(step), .held_addr(held_addr),
        .held_wdata(held_wdata), .chain_set(chain_set), .busy(busy),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    scan_step_decoder #(
        .IR_LEN(IR_LEN), .CHAIN_LEN(CHAIN_LEN), .IR_CHAIN_SEL(IR_CHAIN_SEL),
        .IR_INTEST(IR_INTEST), .CHAIN_ID(CHAIN_ID)
    ) u_dec (
        .step(step), .addr(held_addr), .wdata(held_wdata), .op(op)
    );

    // Drive the engine request and the command handshake.
    always_comb begin
        cmd_ready = !busy;
        sh_req    = busy;
        sh_ir     = op.ir;
        sh_noidle = op.noidle;
        sh_len    = op.len;
        sh_tdi    = op.tdi;
    end

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_req && !sh_ack) |=> (sh_req && $stable(sh_ir) && $stable(sh_len) && $stable(sh_tdi)));
    // R5
    ir_noidle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_req && sh_ir) |-> sh_noidle);
endmodule

// File: tb/tb_dbg_reg_seq.sv
module tb_dbg_reg_seq;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        cmd_valid = 0, cmd_write = 0, raw_ir_load = 0;
    logic [4:0]  cmd_addr = 0;
    logic [31:0] cmd_wdata = 0;
    logic        cmd_ready, busy, rd_valid, sh_req, sh_ir, sh_noidle;
    logic [31:0] rd_data;
    logic [5:0]  sh_len;
    logic [37:0] sh_tdi;
    logic        sh_ack;
    logic [31:0] sh_tdo;

    int n_run = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    dbg_reg_seq dut (.*);

    // Shift engine model: latches request, waits len cycles, pulses ack.
    logic        e_busy;
    int          e_cnt;
    logic        e_ir;
    logic [5:0]  e_len;
    logic [31:0] rd_src = 0;
    int          lg_n = 0;
    logic        lg_ir[0:63];
    logic        lg_ni[0:63];
    logic [5:0]  lg_len[0:63];
    logic [37:0] lg_tdi[0:63];
    int          rd_cnt = 0;
    logic [31:0] rd_last = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            e_busy <= 0; sh_ack <= 0; sh_tdo <= 0; e_cnt <= 0;
        end else if (sh_ack) begin
            sh_ack <= 0;
        end else if (e_busy) begin
            if (e_cnt == 0) begin
                e_busy <= 0; sh_ack <= 1;
                sh_tdo <= (!e_ir && e_len == 6'd32) ? rd_src : 32'hA5A5_0F0F;
            end else e_cnt <= e_cnt - 1;
        end else if (sh_req) begin
            e_busy <= 1; e_cnt <= int'(sh_len); e_ir <= sh_ir; e_len <= sh_len;
            if (lg_n < 64) begin
                lg_ir[lg_n] <= sh_ir; lg_ni[lg_n] <= sh_noidle;
                lg_len[lg_n] <= sh_len; lg_tdi[lg_n] <= sh_tdi;
            end
            lg_n <= lg_n + 1;
        end
    end

    always @(posedge clk) if (rst_n && rd_valid) begin
        rd_cnt <= rd_cnt + 1; rd_last <= rd_data;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_op(input int i, input logic ir, input logic ni, input logic [5:0] len,
                          input logic [37:0] tdi, input string req);
        chk(lg_ir[i] == ir && lg_ni[i] == ni && lg_len[i] == len && lg_tdi[i] == tdi, req,
            {lg_ir[i], lg_ni[i], lg_len[i], lg_tdi[i]}, {ir, ni, len, tdi});
    endtask

    // Issue one command and wait until the access completes.
    task automatic run_cmd(input logic wr, input logic [4:0] a, input logic [31:0] d, output int base);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        base = lg_n;
        cmd_valid = 1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
        @(negedge clk);
        cmd_valid = 0;
        // R1: busy rises the cycle after accept and ready drops
        chk(busy && !cmd_ready, "R1", {busy, cmd_ready}, 2'b10);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic report;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    task automatic t_reset;
        // R9
        chk(!busy && cmd_ready && !sh_req && !rd_valid, "R9",
            {busy, cmd_ready, sh_req, rd_valid}, 4'b0100);
    endtask

    task automatic t_cold_write;
        int b;
        run_cmd(1, 5'h0C, 32'hDEAD_BEEF, b);
        chk(lg_n - b == 4, "R2", lg_n - b, 4);
        chk_op(b,   1, 1, 6'd4, 38'h2, "R2 R5 chain select IR");
        chk_op(b+1, 0, 1, 6'd4, 38'h2, "R2 R5 chain number DR");
        chk_op(b+2, 1, 1, 6'd4, 38'hC, "R2 R5 intest IR");
        chk_op(b+3, 0, 0, 6'd38, {1'b1, 5'h0C, 32'hDEAD_BEEF}, "R6 write scan");
    endtask

    task automatic t_warm_read;
        int b, r0;
        r0 = rd_cnt; rd_src = 32'h1234_5678;
        run_cmd(0, 5'h1F, 0, b);
        chk(lg_n - b == 3, "R3", lg_n - b, 3);
        chk_op(b,   1, 1, 6'd4, 38'hC, "R3 intest IR only");
        chk_op(b+1, 0, 0, 6'd6, 38'h1F, "R7 read address scan");
        chk_op(b+2, 0, 0, 6'd32, 38'h0, "R7 read data scan");
        chk(rd_cnt == r0 + 1, "R7 rd_valid count", rd_cnt, r0 + 1);
        chk(rd_last == 32'h1234_5678, "R7 rd_data", rd_last, 32'h1234_5678);
    endtask

    task automatic t_forget;
        int b;
        @(negedge clk); raw_ir_load = 1;
        @(negedge clk); raw_ir_load = 0;
        run_cmd(1, 5'h00, 32'hFFFF_FFFF, b);
        chk(lg_n - b == 4, "R4", lg_n - b, 4);
        chk_op(b,   1, 1, 6'd4, 38'h2, "R4 reselect IR");
        chk_op(b+1, 0, 1, 6'd4, 38'h2, "R4 reselect DR");
        chk_op(b+3, 0, 0, 6'd38, {1'b1, 5'h00, 32'hFFFF_FFFF}, "R6 write addr 0");
    endtask

    task automatic t_backpressure;
        int b, r0;
        r0 = rd_cnt; rd_src = 32'h0BAD_F00D;
        @(negedge clk);
        b = lg_n;
        cmd_valid = 1; cmd_write = 0; cmd_addr = 5'h03; cmd_wdata = 0;
        @(negedge clk);
        // R8: hold a different write request while busy
        cmd_write = 1; cmd_addr = 5'h15; cmd_wdata = 32'h7777_7777;
        repeat (6) @(negedge clk);
        chk(busy, "R8 still busy", busy, 1);
        cmd_valid = 0;
        while (busy) @(negedge clk);
        repeat (20) @(negedge clk);
        chk(lg_n - b == 3, "R8 no extra requests", lg_n - b, 3);
        chk_op(b+1, 0, 0, 6'd6, 38'h03, "R8 address kept");
        chk(rd_cnt == r0 + 1 && rd_last == 32'h0BAD_F00D, "R8 R7 read result", rd_last, 32'h0BAD_F00D);
    endtask

    task automatic t_top_addr_write;
        int b;
        run_cmd(1, 5'h1F, 32'h0000_0001, b);
        chk(lg_n - b == 2, "R3 warm write", lg_n - b, 2);
        chk_op(b+1, 0, 0, 6'd38, {1'b1, 5'h1F, 32'h1}, "R6 write addr 31");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_cold_write();
        t_warm_read();
        t_forget();
        t_backpressure();
        t_top_addr_write();
        report();
    end
endmodule